// File: doc/BRIEF.md
# Eight-Level Polled Interrupt Controller

The block gathers eight edge-triggered interrupt inputs and presents them to software through a two-address byte port. Address 0 takes command words and returns status. Address 1 takes and returns the 8-bit mask. Software first issues a start-of-setup command, which is followed by up to three setup words on the data address. It then uses poll commands to claim the most urgent request, and a specific end-of-interrupt command to retire it. The block has no vectored acknowledge cycle. A poll read is the only way a request becomes in service.

Two copies can be chained. The single-bit request output of one copy (the slave) drives input 2 of the other (the master). When a master poll reports level 2, software polls the slave to find the real source. Retiring the interrupt then needs one end-of-interrupt at the slave and a second one, for level 2, at the master. When a poll finds nothing that may be granted, it reports level 7 with its valid flag clear and leaves in-service bit 7 at zero. Software detects a spurious event by checking that bit.

Top module: `pic8_core`

## Requirements
- R1: After reset the mask is 0xFF, the request and in-service registers are 0, command-address reads return the request register, poll mode is off and `irq_out` is low.
- R2: A rising edge on `req_in[n]` sets request bit n. An input that is held high sets the bit only once. The bit stays set until a poll grants level n.
- R3: A command write with bit 4 set starts setup and clears the request and in-service registers. The data writes that follow are consumed in order, and none of them changes the mask: a base word, then a cascade word if bit 1 of the start command was 0, then a mode word if bit 0 of the start command was 1.
- R4: Outside setup, a data-address write loads the mask and a data-address read returns it. A mask bit of 1 keeps that level from being granted, but its request bit is still recorded.
- R5: A command write of the form 0b0000_1x1s (bit 3 set, bit 2 clear, bit 1 set) selects the status source: s=0 selects the request register and s=1 selects the in-service register.
- R6: A command write with bit 3 set and bit 2 set (0x0C) arms a poll. The next command read returns {valid, 4'b0, level[2:0]}. On a valid poll the read sets in-service bit `level` and clears request bit `level`. Poll mode ends after that one read, and later reads return the selected status register again.
- R7: Level 0 has the highest priority and level 7 the lowest. The unmasked pending level with the lowest index is granted only if no in-service bit at that index or a lower index is set.
- R8: A poll with nothing grantable returns 0x07 and leaves the in-service register unchanged. In particular, bit 7 stays clear.
- R9: Outside setup, a command write of 0x60+n clears in-service bit n and no other bit.
- R10: `irq_out` is high exactly when a grantable request exists.
- R11: When a slave's `irq_out` drives master input 2, a master poll returns 0x82 and a slave poll returns the slave level. Clearing both in-service registers takes one end-of-interrupt at each controller.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | 8 | Edge-sensitive interrupt inputs, index 0 most urgent |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle; read side effects take place at the clock edge |
| addr | input | 1 | 0 = command/status, 1 = mask/data |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid during `rd_en`, 0 otherwise |
| irq_out | output | 1 | A grantable request is pending |

## Verification
The bench builds two copies with the default eight-level width and chains them as master and slave. This makes the cascade path reachable: a slave request travels through the master's input 2, and the two end-of-interrupts are checked in order. The same pair is used for the full setup sequence and for the shortened single-controller setup that has a mode word and no cascade word. The bench also drives nested in-service blocking, masked-but-recorded requests, a true level-7 request and a spurious poll.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
    localparam int NUM_LVL = 8;
    localparam int LVL_W   = $clog2(NUM_LVL);

    typedef enum logic [1:0] {
        PH_RUN  = 2'd0,
        PH_BASE = 2'd1,
        PH_CASC = 2'd2,
        PH_MODE = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e               phase;
        logic                 want_casc;
        logic                 want_mode;
        logic [NUM_LVL-1:0]   irr;
        logic [NUM_LVL-1:0]   isr;
        logic [NUM_LVL-1:0]   imr;
        logic                 sel_isr;
        logic                 poll;
    } pic_state_t;

    localparam logic [2:0] EOI_SPECIFIC = 3'b011;
endpackage

// File: rtl/pic8_edge.sv
module pic8_edge #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_in,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] prev_q;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q[g] <= 1'b0;
            else        prev_q[g] <= lvl_in[g];
        end
        assign rise[g] = lvl_in[g] & ~prev_q[g];
    end
endmodule

// File: rtl/pic8_prio.sv
module pic8_prio #(
    parameter int WIDTH = 8,
    localparam int LW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] irr,
    input  logic [WIDTH-1:0] imr,
    input  logic [WIDTH-1:0] isr,
    output logic             grant,
    output logic [LW-1:0]    level
);
    logic [WIDTH-1:0] cand;
    logic             found;
    logic             blocked;

    always_comb begin
        cand    = irr & ~imr;
        found   = 1'b0;
        level   = LW'(WIDTH - 1);
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                level = LW'(i);
            end
        end
        blocked = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            if (isr[i] && (LW'(i) <= level)) blocked = 1'b1;
        end
        grant = found && !blocked;
        if (!grant) level = LW'(WIDTH - 1);
    end
endmodule

// File: rtl/pic8_core.sv
module pic8_core
    import pic8_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] req_in,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic       addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq_out
);
    pic_state_t         state_q, state_d;
    logic [NUM_LVL-1:0] rise;
    logic               grant;
    logic [LVL_W-1:0]   grant_lvl;
    logic               cmd_rd;

    pic8_edge #(.WIDTH(NUM_LVL)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_in (req_in),
        .rise   (rise)
    );

    pic8_prio #(.WIDTH(NUM_LVL)) u_prio (
        .irr   (state_q.irr),
        .imr   (state_q.imr),
        .isr   (state_q.isr),
        .grant (grant),
        .level (grant_lvl)
    );

    assign cmd_rd  = rd_en && !addr;
    assign irq_out = grant;

    always_comb begin
        if (!rd_en)            rdata = '0;
        else if (addr)         rdata = state_q.imr;
        else if (state_q.poll) rdata = {grant, 4'b0000, grant_lvl};
        else if (state_q.sel_isr) rdata = state_q.isr;
        else                   rdata = state_q.irr;
    end

    always_comb begin
        state_d = state_q;
        if (cmd_rd) begin
            state_d.poll = 1'b0;
            if (state_q.poll && grant) begin
                state_d.isr[grant_lvl] = 1'b1;
                state_d.irr[grant_lvl] = 1'b0;
            end
        end
        if (wr_en) begin
            if (!addr) begin
                if (wdata[4]) begin
                    state_d.phase     = PH_BASE;
                    state_d.want_casc = !wdata[1];
                    state_d.want_mode = wdata[0];
                    state_d.irr       = '0;
                    state_d.isr       = '0;
                    state_d.sel_isr   = 1'b0;
                    state_d.poll      = 1'b0;
                end else if (state_q.phase == PH_RUN) begin
                    if (wdata[3]) begin
                        if (wdata[1]) state_d.sel_isr = wdata[0];
                        state_d.poll = wdata[2];
                    end else if (wdata[7:5] == EOI_SPECIFIC) begin
                        state_d.isr[wdata[2:0]] = 1'b0;
                    end
                end
            end else begin
                case (state_q.phase)
                    PH_RUN:  state_d.imr = wdata;
                    PH_BASE: state_d.phase = state_q.want_casc ? PH_CASC :
                                             (state_q.want_mode ? PH_MODE : PH_RUN);
                    PH_CASC: state_d.phase = state_q.want_mode ? PH_MODE : PH_RUN;
                    default: state_d.phase = PH_RUN;
                endcase
            end
        end
        state_d.irr = state_d.irr | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.phase     <= PH_RUN;
            state_q.want_casc <= 1'b0;
            state_q.want_mode <= 1'b0;
            state_q.irr       <= '0;
            state_q.isr       <= '0;
            state_q.imr       <= '1;
            state_q.sel_isr   <= 1'b0;
            state_q.poll      <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/pic8_checker.sv
module pic8_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic       addr,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       irq_out,
    input logic       running,
    input logic       poll,
    input logic [7:0] irr,
    input logic [7:0] isr,
    input logic [7:0] imr
);
    AST_GRANT_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((irr & ~imr) != 8'h00)) else $error("grant without unmasked request"); // R10

    AST_POLL_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !addr && poll && rdata[7]) |=> isr[$past(rdata[2:0])]) else $error("poll did not set isr"); // R6

    AST_SPURIOUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !addr && poll && !rdata[7] && !wr_en) |=> $stable(isr)) else $error("spurious poll touched isr"); // R8

    AST_SPURIOUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !addr && poll && !rdata[7]) |-> (rdata == 8'h07)) else $error("spurious code wrong"); // R8

    AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && running && wdata[7:5] == 3'b011 && !rd_en) |=> !isr[$past(wdata[2:0])]) else $error("eoi missed"); // R9

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && running) |=> (imr == $past(wdata))) else $error("mask not loaded"); // R4

    AST_SETUP_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && !running) |=> $stable(imr)) else $error("setup word hit mask"); // R3
endmodule

bind pic8_core pic8_checker u_pic8_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .irq_out (irq_out),
    .running (state_q.phase == pic8_pkg::PH_RUN),
    .poll    (state_q.poll),
    .irr     (state_q.irr),
    .isr     (state_q.isr),
    .imr     (state_q.imr)
);

// File: tb/pic8_core_bench.sv
module pic8_core_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] m_req = '0;
    logic [7:0] s_req = '0;
    logic       m_wr = 1'b0, m_rd = 1'b0, s_wr = 1'b0, s_rd = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] m_rdata, s_rdata;
    logic       m_irq, s_irq;
    logic [7:0] m_in;
    int         n_checks = 0;
    int         n_fail = 0;

    assign m_in = {m_req[7:3], s_irq, m_req[1:0]};

    always #(CLK_PERIOD/2) clk = ~clk;

    pic8_core u_pic8_core (
        .clk(clk), .rst_n(rst_n), .req_in(m_in), .wr_en(m_wr), .rd_en(m_rd),
        .addr(addr), .wdata(wdata), .rdata(m_rdata), .irq_out(m_irq)
    );

    pic8_core u_slave (
        .clk(clk), .rst_n(rst_n), .req_in(s_req), .wr_en(s_wr), .rd_en(s_rd),
        .addr(addr), .wdata(wdata), .rdata(s_rdata), .irq_out(s_irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input bit slv, input logic a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d;
        if (slv) s_wr = 1'b1; else m_wr = 1'b1;
        @(negedge clk);
        m_wr = 1'b0; s_wr = 1'b0;
    endtask

    task automatic rd(input bit slv, input logic a, output logic [7:0] v);
        @(negedge clk);
        addr = a;
        if (slv) s_rd = 1'b1; else m_rd = 1'b1;
        #(CLK_PERIOD/4);
        v = slv ? s_rdata : m_rdata;
        @(negedge clk);
        m_rd = 1'b0; s_rd = 1'b0;
    endtask

    task automatic poll(input bit slv, output logic [7:0] v);
        wr(slv, 1'b0, 8'h0C);
        rd(slv, 1'b0, v);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(1'b0, 1'b0, v); check("R1 irr", v, 8'h00);
        rd(1'b0, 1'b1, v); check("R1 mask", v, 8'hFF);
        check("R1 irq", {7'b0, m_irq}, 8'h00);
        wr(1'b0, 1'b0, 8'h0B);
        rd(1'b0, 1'b0, v); check("R1 isr", v, 8'h00);
        wr(1'b0, 1'b0, 8'h0A);
    endtask

    task automatic t_setup();
        logic [7:0] v;
        wr(1'b0, 1'b0, 8'h11);
        wr(1'b0, 1'b1, 8'h20);
        wr(1'b0, 1'b1, 8'h04);
        wr(1'b0, 1'b1, 8'h01);
        rd(1'b0, 1'b1, v); check("R3 mask kept", v, 8'hFF);
        wr(1'b0, 1'b1, 8'h00);
        rd(1'b0, 1'b1, v); check("R4 mask load", v, 8'h00);
        wr(1'b1, 1'b0, 8'h11);
        wr(1'b1, 1'b1, 8'h28);
        wr(1'b1, 1'b1, 8'h02);
        wr(1'b1, 1'b1, 8'h01);
        wr(1'b1, 1'b1, 8'h00);
        rd(1'b1, 1'b1, v); check("R3 slave mask", v, 8'h00);
    endtask

    task automatic t_mask();
        logic [7:0] v;
        wr(1'b0, 1'b1, 8'hDF);
        m_req[4] = 1'b1; m_req[5] = 1'b1;
        tick(2);
        rd(1'b0, 1'b0, v); check("R2 irr edges", v, 8'h30);
        check("R10 irq high", {7'b0, m_irq}, 8'h01);
        poll(1'b0, v); check("R4 masked skipped", v, 8'h85);
        rd(1'b0, 1'b0, v); check("R6 poll once, irr", v, 8'h10);
        wr(1'b0, 1'b0, 8'h0B);
        rd(1'b0, 1'b0, v); check("R5 isr select", v, 8'h20);
        wr(1'b0, 1'b0, 8'h65);
        rd(1'b0, 1'b0, v); check("R9 eoi", v, 8'h00);
        check("R4 masked no irq", {7'b0, m_irq}, 8'h00);
        wr(1'b0, 1'b0, 8'h0A);
    endtask

    task automatic t_priority();
        logic [7:0] v;
        wr(1'b0, 1'b1, 8'h00);
        m_req[1] = 1'b1; m_req[6] = 1'b1;
        tick(2);
        rd(1'b0, 1'b0, v); check("R2 held no reset", v, 8'h52);
        poll(1'b0, v); check("R7 highest first", v, 8'h81);
        check("R7 nested blocks irq", {7'b0, m_irq}, 8'h00);
        poll(1'b0, v); check("R7 nested poll", v, 8'h07);
        wr(1'b0, 1'b0, 8'h61);
        poll(1'b0, v); check("R7 next level", v, 8'h84);
        wr(1'b0, 1'b0, 8'h64);
        poll(1'b0, v); check("R7 last level", v, 8'h86);
        m_req[0] = 1'b1;
        tick(2);
        check("R10 higher over isr", {7'b0, m_irq}, 8'h01);
        poll(1'b0, v); check("R7 preempt", v, 8'h80);
        wr(1'b0, 1'b0, 8'h0B);
        rd(1'b0, 1'b0, v); check("R6 isr bits", v, 8'h41);
        wr(1'b0, 1'b0, 8'h66);
        rd(1'b0, 1'b0, v); check("R9 only one bit", v, 8'h01);
        wr(1'b0, 1'b0, 8'h60);
        rd(1'b0, 1'b0, v); check("R9 cleared", v, 8'h00);
        wr(1'b0, 1'b0, 8'h0A);
        m_req = '0;
        tick(1);
    endtask

    task automatic t_spurious();
        logic [7:0] v;
        poll(1'b0, v); check("R8 empty poll", v, 8'h07);
        wr(1'b0, 1'b0, 8'h0B);
        rd(1'b0, 1'b0, v); check("R8 isr7 clear", v, 8'h00);
        m_req[7] = 1'b1;
        tick(2);
        poll(1'b0, v); check("R8 real level 7", v, 8'h87);
        rd(1'b0, 1'b0, v); check("R8 isr7 set", v, 8'h80);
        wr(1'b0, 1'b0, 8'h67);
        wr(1'b0, 1'b0, 8'h0A);
        m_req = '0;
        tick(1);
    endtask

    task automatic t_cascade();
        logic [7:0] v;
        s_req[3] = 1'b1;
        tick(3);
        check("R11 master irq", {7'b0, m_irq}, 8'h01);
        poll(1'b0, v); check("R11 master poll", v, 8'h82);
        poll(1'b1, v); check("R11 slave poll", v, 8'h83);
        check("R11 slave irq low", {7'b0, s_irq}, 8'h00);
        wr(1'b1, 1'b0, 8'h63);
        wr(1'b1, 1'b0, 8'h0B);
        rd(1'b1, 1'b0, v); check("R11 slave isr", v, 8'h00);
        wr(1'b0, 1'b0, 8'h0B);
        rd(1'b0, 1'b0, v); check("R11 master isr kept", v, 8'h04);
        wr(1'b0, 1'b0, 8'h62);
        rd(1'b0, 1'b0, v); check("R11 master isr", v, 8'h00);
        s_req = '0;
        tick(1);
    endtask

    task automatic t_short_setup();
        logic [7:0] v;
        s_req[5] = 1'b1;
        tick(2);
        wr(1'b1, 1'b0, 8'h13);
        rd(1'b1, 1'b0, v); check("R3 irr cleared", v, 8'h00);
        wr(1'b1, 1'b1, 8'h30);
        wr(1'b1, 1'b1, 8'h01);
        rd(1'b1, 1'b1, v); check("R3 short kept", v, 8'h00);
        wr(1'b1, 1'b1, 8'h5A);
        rd(1'b1, 1'b1, v); check("R3 short then mask", v, 8'h5A);
        s_req = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_setup();
        t_mask();
        t_priority();
        t_spurious();
        t_cascade();
        t_short_setup();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule